// File: doc/BRIEF.md
# Calibration Pulse Train Generator

This block turns a stream of non-negative real-power samples into one fast pulse train for meter calibration. Each sample that arrives with its strobe is added to a running total. Each time the total reaches a threshold, the block raises the calibration line and carries the overshoot into the next interval. The threshold is a fixed fraction of the threshold used by the slow energy outputs elsewhere in the meter, so the calibration rate is a fixed multiple of the slow rate. The block keeps its own total and has no timing tie to the slow outputs.

A three-bit mode sets the multiple. It is made of a calibration-select bit and a two-bit base-rate select. The pulse width depends on the mode and on the length of the interval that has just ended. A slow train gets a fixed wide pulse. A fast train gets about half its period, and one mode gets about two thirds of it. The high-rate mode always gets a very short pulse. Samples below a small no-load floor are dropped, so an idle meter does not creep. Each rising edge also gives a one-cycle strobe that other logic can count.

Top module: `cal_pulse_gen`

## Requirements
- R1: While reset is asserted, `cal_pulse` and `cal_issued` are low and the running total is cleared. A reset that arrives during a pulse forces `cal_pulse` low at once.
- R2: A strobed sample at or above the floor is added to the total. When total plus sample is greater than or equal to the threshold, the pulse rises on that clock edge and the excess is kept. Reaching the threshold exactly counts as a crossing.
- R3: Mode index = {cal_sel, rate_sel[1], rate_sel[0]}. The slow-output threshold is UNIT·8, UNIT·4, UNIT·2 or UNIT·1 for rate_sel 0, 1, 2 or 3. The calibration threshold is that value divided by a multiplier. The multipliers for index 0 to 7 are 128, 64, 64, 2048, 160, 80, 40 and 16. A total equal to one slow-output threshold therefore gives exactly that many pulses.
- R4: A strobed sample below NOLOAD (default 4) leaves the total unchanged and cannot cause a pulse. A sample equal to NOLOAD is accumulated.
- R5: In any mode other than index 3, if the measured period is at least 2·WIDE_CYC clock cycles, the pulse is high for WIDE_CYC cycles. The measured period is the number of cycles since the previous crossing, saturating at 2·WIDE_CYC.
- R6: In any mode other than indices 1 and 3, a measured period P below 2·WIDE_CYC gives a width of floor(P/2) cycles, with a minimum of 1.
- R7: In mode index 1, a measured period P below 2·WIDE_CYC gives a width of floor(2·P/3) cycles, with a minimum of 1.
- R8: In mode index 3 (high-rate mode), every pulse is HF_CYC cycles wide (default 1), whatever the period.
- R9: `cal_issued` is high for exactly the one cycle that follows each rising edge of `cal_pulse`, and at no other time.
- R10: The first crossing after reset sees a saturated period, so its width is WIDE_CYC (HF_CYC in mode 3).
- R11: A crossing that occurs while the pulse is high is held. The current pulse finishes, the line stays low for one cycle, and then a new pulse rises. The new pulse's width comes from the period measured at the held crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe, one cycle per power sample |
| smp_power | input | PW | Unsigned real-power sample |
| cal_sel | input | 1 | Calibration-rate select, high bit of the mode index |
| rate_sel | input | 2 | Base-rate select, low bits of the mode index |
| cal_pulse | output | 1 | Active-high calibration pulse train |
| cal_issued | output | 1 | One-cycle strobe after each rising edge of cal_pulse |

## Verification
The properties assume that the mode inputs stay steady while samples are flowing. They also assume that no single sample is larger than the smallest calibration threshold, so that one sample causes at most one crossing. The width bound assumes HF_CYC does not exceed 2·WIDE_CYC. The bench resets the block before each mode change, uses samples no larger than 8192 against a smallest threshold of 10240, and keeps the default widths.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  localparam int unsigned NUM_MODES = 8;

  typedef logic [2:0] mode_t;

  // index = {cal_sel, rate_sel}
  localparam mode_t MODE_HF   = 3'b011;
  localparam mode_t MODE_DUTY = 3'b001;

  // calibration multiple over the slow output, per mode index
  function automatic int unsigned mode_mult(input int unsigned idx);
    int unsigned m;
    case (idx)
      0:       m = 128;
      1:       m = 64;
      2:       m = 64;
      3:       m = 2048;
      4:       m = 160;
      5:       m = 80;
      6:       m = 40;
      default: m = 16;
    endcase
    return m;
  endfunction

  // relative slow-output threshold for a base-rate select value
  function automatic int unsigned rate_weight(input int unsigned rate);
    return 32'd8 >> (rate % 4);
  endfunction

endpackage

// File: rtl/cfp_accum.sv
module cfp_accum
  import cfp_pkg::*;
#(
  parameter int unsigned PW     = 14,
  parameter int unsigned UNIT   = 20971520,
  parameter int unsigned NOLOAD = 4,
  parameter int unsigned AW     = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [PW-1:0] smp_power,
  input  mode_t         mode,
  output logic          fire
);

  logic [AW-1:0] thr_tab [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_thr
    localparam longint unsigned TV =
      (64'(UNIT) * 64'(rate_weight(unsigned'(g)))) / 64'(mode_mult(unsigned'(g)));
    assign thr_tab[g] = AW'(TV);
  end

  logic [AW-1:0] acc_q, acc_d, sum_w, thr_w;
  logic          take_w;
  logic          acc_en;

  always_comb begin
    thr_w  = thr_tab[mode];
    sum_w  = acc_q + AW'(smp_power);
    take_w = smp_valid && (smp_power >= PW'(NOLOAD));
    acc_en = take_w;
    acc_d  = acc_q;
    fire   = 1'b0;
    if (take_w) begin
      if (sum_w >= thr_w) begin
        fire  = 1'b1;
        acc_d = sum_w - thr_w;
      end else begin
        acc_d = sum_w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/cfp_period.sv
module cfp_period #(
  parameter int unsigned CW   = 8,
  parameter int unsigned PMAX = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  output logic [CW-1:0] period
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sat_w;

  always_comb begin
    sat_w  = (cnt_q == CW'(PMAX));
    period = sat_w ? cnt_q : cnt_q + CW'(1);
    if (fire) begin
      cnt_d = '0;
    end else if (sat_w) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(PMAX);
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cfp_shaper.sv
module cfp_shaper
  import cfp_pkg::*;
#(
  parameter int unsigned CW       = 8,
  parameter int unsigned PMAX     = 200,
  parameter int unsigned WIDE_CYC = 100,
  parameter int unsigned HF_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [CW-1:0] period,
  input  mode_t         mode,
  output logic          cf_out,
  output logic          issued
);

  logic [CW:0]   twice_w;
  logic [CW-1:0] w_calc;

  always_comb begin
    twice_w = {period, 1'b0};
    if (mode == MODE_HF) begin
      w_calc = CW'(HF_CYC);
    end else if (period >= CW'(PMAX)) begin
      w_calc = CW'(WIDE_CYC);
    end else if (mode == MODE_DUTY) begin
      w_calc = CW'(twice_w / (CW+1)'(3));
    end else begin
      w_calc = period >> 1;
    end
    if (w_calc == '0) begin
      w_calc = CW'(1);
    end
  end

  logic          cf_q, cf_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] pend_w_q, pend_w_d;
  logic          pend_w_en;
  logic          iss_q, iss_d;

  always_comb begin
    cf_d      = cf_q;
    cnt_d     = cnt_q;
    pend_d    = pend_q;
    pend_w_d  = pend_w_q;
    pend_w_en = 1'b0;
    iss_d     = 1'b0;
    if (cf_q) begin
      if (cnt_q == '0) begin
        cf_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
      if (fire) begin
        pend_d    = 1'b1;
        pend_w_d  = w_calc;
        pend_w_en = 1'b1;
      end
    end else if (pend_q) begin
      cf_d   = 1'b1;
      cnt_d  = pend_w_q - CW'(1);
      iss_d  = 1'b1;
      pend_d = fire;
      if (fire) begin
        pend_w_d  = w_calc;
        pend_w_en = 1'b1;
      end
    end else if (fire) begin
      cf_d  = 1'b1;
      cnt_d = w_calc - CW'(1);
      iss_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_q   <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      iss_q  <= 1'b0;
    end else begin
      cf_q   <= cf_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      iss_q  <= iss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_w_q <= '0;
    end else if (pend_w_en) begin
      pend_w_q <= pend_w_d;
    end
  end

  assign cf_out = cf_q;
  assign issued = iss_q;

endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen
  import cfp_pkg::*;
#(
  parameter int unsigned PW       = 14,
  parameter int unsigned UNIT     = 20971520,
  parameter int unsigned NOLOAD   = 4,
  parameter int unsigned WIDE_CYC = 100,
  parameter int unsigned HF_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [PW-1:0] smp_power,
  input  logic          cal_sel,
  input  logic [1:0]    rate_sel,
  output logic          cal_pulse,
  output logic          cal_issued
);

  localparam int unsigned PMAX = 2 * WIDE_CYC;
  localparam int unsigned CW   = $clog2(PMAX + 1);
  localparam int unsigned AW   = $clog2(UNIT) + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  mode_t         mode_w;
  logic          fire_w;
  logic [CW-1:0] period_w;

  assign mode_w = {cal_sel, rate_sel};

  cfp_accum #(
    .PW(PW), .UNIT(UNIT), .NOLOAD(NOLOAD), .AW(AW)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .smp_valid (smp_valid),
    .smp_power (smp_power),
    .mode      (mode_w),
    .fire      (fire_w)
  );

  cfp_period #(
    .CW(CW), .PMAX(PMAX)
  ) u_period (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .fire   (fire_w),
    .period (period_w)
  );

  cfp_shaper #(
    .CW(CW), .PMAX(PMAX), .WIDE_CYC(WIDE_CYC), .HF_CYC(HF_CYC)
  ) u_shaper (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .fire   (fire_w),
    .period (period_w),
    .mode   (mode_w),
    .cf_out (cal_pulse),
    .issued (cal_issued)
  );

endmodule

// File: rtl/cal_pulse_gen_chk.sv
module cal_pulse_gen_chk #(
  parameter int unsigned PW       = 14,
  parameter int unsigned NOLOAD   = 4,
  parameter int unsigned WIDE_CYC = 100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [PW-1:0] smp_power,
  input logic          cal_pulse,
  input logic          cal_issued,
  input logic          fire
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (cal_pulse) begin
      run_q <= run_q + 32'd1;
    end else begin
      run_q <= '0;
    end
  end

  // R9: strobe only right after a rising edge
  p_issue_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_issued |-> (cal_pulse && !$past(cal_pulse)));

  // R9: every rising edge is flagged
  p_rise_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_pulse && !$past(cal_pulse)) |-> cal_issued);

  // R9: strobe lasts one cycle
  p_issue_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_issued |=> !cal_issued);

  // R4: a sample under the floor never produces a crossing
  p_noload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_power < PW'(NOLOAD))) |-> !fire);

  // R5: no high run exceeds the widest allowed width
  p_width_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 32'(2 * WIDE_CYC));

endmodule

bind cal_pulse_gen cal_pulse_gen_chk #(
  .PW(PW), .NOLOAD(NOLOAD), .WIDE_CYC(WIDE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_power  (smp_power),
  .cal_pulse  (cal_pulse),
  .cal_issued (cal_issued),
  .fire       (fire_w)
);

// File: tb/cal_pulse_gen_tb.sv
module cal_pulse_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 14;

  logic          clk;
  logic          rst_n;
  logic          smp_valid;
  logic [PW-1:0] smp_power;
  logic          cal_sel;
  logic [1:0]    rate_sel;
  logic          cal_pulse;
  logic          cal_issued;

  cal_pulse_gen #(.PW(PW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_power  (smp_power),
    .cal_sel    (cal_sel),
    .rate_sel   (rate_sel),
    .cal_pulse  (cal_pulse),
    .cal_issued (cal_issued)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  int rise_cnt, w_cnt, iss_cnt, iss_bad, cur_w, max_w;
  int rise_t [16];
  int wid [16];
  bit prev_cf;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cal_pulse && !prev_cf) begin
      if (rise_cnt < 16) rise_t[rise_cnt] = cyc;
      rise_cnt = rise_cnt + 1;
      cur_w = 1;
    end else if (cal_pulse) begin
      cur_w = cur_w + 1;
    end
    if (!cal_pulse && prev_cf) begin
      if (w_cnt < 16) wid[w_cnt] = cur_w;
      w_cnt = w_cnt + 1;
      if (cur_w > max_w) max_w = cur_w;
    end
    if (cal_issued) iss_cnt = iss_cnt + 1;
    if (cal_issued != (cal_pulse && !prev_cf)) iss_bad = iss_bad + 1;
    prev_cf = cal_pulse;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic feed(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_power = p[PW-1:0];
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_power = '0;
    {cal_sel, rate_sel} = m;
    idle(3);
    rise_cnt = 0; w_cnt = 0; iss_cnt = 0; iss_bad = 0; cur_w = 0; max_w = 0;
    rst_n = 1'b1;
    idle(3);
  endtask

  // R1: reset state and reset during a pulse
  task automatic t_reset();
    do_reset(3'b010);
    check("R1 pulse low after reset", cal_pulse, 0);
    check("R1 strobe low after reset", cal_issued, 0);
    feed(8192, 80);
    idle(5);
    check("R1 pulse high before mid-pulse reset", cal_pulse, 1);
    rst_n = 1'b0;
    #1;
    check("R1 pulse forced low by reset", cal_pulse, 0);
    do_reset(3'b010);
    feed(8192, 79);
    idle(3);
    check("R1 total cleared (no pulse after 79 samples)", rise_cnt, 0);
  endtask

  // R3 R8 R9: high-rate mode, 2048 pulses of width 1 per slow threshold
  task automatic t_highrate();
    do_reset(3'b011);
    feed(4096, 5120);
    idle(5);
    check("R3 high-rate multiple", rise_cnt, 2048);
    check("R8 every width one cycle", max_w, 1);
    check("R9 strobe count", iss_cnt, 2048);
    check("R9 strobe aligned to edges", iss_bad, 0);
  endtask

  // R3: multiples 16 and 160
  task automatic t_multiples();
    do_reset(3'b111);
    feed(4096, 5120);
    idle(250);
    check("R3 multiple mode 7", rise_cnt, 16);
    do_reset(3'b100);
    feed(4096, 40960);
    idle(250);
    check("R3 multiple mode 4", rise_cnt, 160);
    check("R9 strobe aligned mode 4", iss_bad, 0);
  endtask

  // R5 R10: slow train gets the wide width
  task automatic t_wide();
    do_reset(3'b111);
    feed(4096, 640);
    idle(250);
    check("R5 pulse count", rise_cnt, 2);
    check("R10 first width wide", wid[0], 100);
    check("R5 second width wide", wid[1], 100);
    check("R2 crossing spacing", rise_t[1] - rise_t[0], 320);
  endtask

  // R6 R11: half period and a held crossing
  task automatic t_half();
    do_reset(3'b010);
    feed(8192, 240);
    idle(250);
    check("R11 pulse count", rise_cnt, 3);
    check("R10 first width wide", wid[0], 100);
    check("R6 half-period width", wid[1], 40);
    check("R6 half-period width again", wid[2], 40);
    check("R11 held pulse rise delay", rise_t[1] - rise_t[0], 101);
    check("R2 third crossing", rise_t[2] - rise_t[0], 160);
  endtask

  // R7: two-thirds duty mode
  task automatic t_duty();
    do_reset(3'b001);
    feed(8192, 480);
    idle(250);
    check("R7 pulse count", rise_cnt, 3);
    check("R7 two-thirds width", wid[1], 106);
    check("R7 two-thirds width again", wid[2], 106);
    check("R7 spacing", rise_t[2] - rise_t[1], 160);
  endtask

  // R4 R2: floor and exact threshold
  task automatic t_noload();
    do_reset(3'b011);
    feed(3, 1000);
    idle(3);
    check("R4 sub-floor samples give no pulse", rise_cnt, 0);
    feed(4096, 2);
    idle(3);
    check("R4 sub-floor samples not accumulated", rise_cnt, 0);
    feed(4096, 1);
    idle(3);
    check("R2 crossing on third sample", rise_cnt, 1);
    do_reset(3'b011);
    feed(4, 2559);
    idle(3);
    check("R4 floor-level samples, just short", rise_cnt, 0);
    feed(4, 1);
    idle(3);
    check("R2 exact threshold crossing", rise_cnt, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_power = '0;
    cal_sel = 1'b0;
    rate_sel = 2'b00;
    prev_cf = 1'b0;
    t_reset();
    t_highrate();
    t_multiples();
    t_wide();
    t_half();
    t_duty();
    t_noload();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule